// File: doc/BRIEF.md
# Write-Update Snooping Coherence Controller

This block keeps a small direct-mapped cache coherent on a snooping bus. Peers are updated rather than invalidated. Each line holds one data word. A resident line carries a valid bit and one of three sharing states:

- sole-clean (code 0)
- shared-clean (code 1)
- sole-dirty (code 2)

A line in a sole state behaves write-back. A shared line behaves write-through: every write goes out on the bus to memory and to every peer copy.

The processor issues single-word reads and writes. The controller walks a state machine with these states:

- `IDLE`: waits for a request.
- `TAG`: looks up the line.
- `EVICT`: writes back a dirty victim.
- `MISS`: issues a read-miss or write-miss and installs the line.
- `UPD`: broadcasts an update write.
- `RESP`: completes the request.

The transitions are:

- `IDLE`→`TAG` on a request.
- `TAG`→`RESP` on a read hit or a write hit in a sole state.
- `TAG`→`UPD` on a write hit in the shared state.
- `TAG`→`EVICT` on a miss whose victim is sole-dirty.
- `TAG`→`MISS` on any other miss.
- `EVICT`→`MISS`.
- `MISS`→`UPD` on a write miss that found sharers.
- `MISS`→`RESP` otherwise.
- `UPD`→`RESP`.
- `RESP`→`IDLE`.

Any state other than `IDLE` and `RESP` holds while a peer command occupies the bus.

On the snoop side, the controller watches peer commands. When it holds a matching line, it drives the shared response, supplies its data and moves the line to shared-clean. The shared-response input is the wired-OR of the peers' responses. It is sampled in the cycle of the controller's own command.

The address splits into a line index (low bits) and a tag (high bits). Bus command codes are:

| Code | Command |
|------|---------|
| 0 | none |
| 1 | read-miss |
| 2 | write-miss |
| 3 | update write |
| 4 | write-back |

Top module: `wupd_coherence_ctrl`

## Requirements
- R1: After reset every line is invalid, `cpu_ready` is high, `cpu_done` is low and `bus_cmd` is 0; a snoop of any address gets no shared response.
- R2: A read hit issues no bus command, leaves the state unchanged and returns the line data with a one-cycle `cpu_done` pulse, after which `cpu_ready` is high again.
- R3: A read miss issues read-miss (code 1) at the request address. With `bus_shared` low the line is filled from `bus_rdata` as sole-clean. With `bus_shared` high it is filled from the supplied data as shared-clean.
- R4: A write miss issues write-miss (code 2). With `bus_shared` low the line takes the write data as sole-dirty and nothing else is issued. With `bus_shared` high it is followed by an update write (code 3) carrying the written word, and the line becomes shared-clean.
- R5: A write hit on a sole-clean or sole-dirty line is performed locally with no bus command and leaves the line sole-dirty.
- R6: A write hit on a shared-clean line issues exactly one update write (code 3) with the request address and data, and the line stays shared-clean.
- R7: A miss whose victim is sole-dirty first issues write-back (code 4) with the victim's address and data, then the miss command. A clean victim is replaced with no write-back.
- R8: A snooped read-miss or write-miss that matches a valid line raises `snp_shared`, drives the line data on `snp_data_out` and makes the line shared-clean. `snp_flush` is high only for a read-miss that hits a sole-dirty line.
- R9: A snooped update write that matches a valid line raises `snp_shared`, overwrites the line with `snp_data_in` and leaves it shared-clean.
- R10: A snooped command that does not match a valid line, and any snooped write-back, gives no shared response and changes no line.
- R11: While `snp_cmd` is non-zero the controller issues no bus command and makes no processor-side line change. A request whose lookup meets such a cycle is decided afresh on the line state the snoop leaves behind.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Request strobe, taken while `cpu_ready` is high |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Request word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Controller idle, able to take a request |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Line data, valid with `cpu_done` |
| bus_cmd | output | 3 | Command issued this cycle (codes above) |
| bus_addr | output | ADDR_W | Command address |
| bus_wdata | output | DATA_W | Data for update write and write-back |
| bus_shared | input | 1 | Wired-OR shared response of peers to own command |
| bus_rdata | input | DATA_W | Fill data returned in the read/write-miss cycle |
| snp_cmd | input | 3 | Peer command observed on the bus |
| snp_addr | input | ADDR_W | Peer command address |
| snp_data_in | input | DATA_W | Peer update-write data |
| snp_shared | output | 1 | This cache holds the snooped line |
| snp_data_out | output | DATA_W | Line data supplied to a peer miss |
| snp_flush | output | 1 | Supplied data is dirty and memory must take it |

## Verification
The hardest situation to reach is a peer command that lands in the cycle the controller is looking up a line it is about to write. The snoop changes the line's state under the pending request, so the stall and re-evaluation decide whether a local write or an update write follows. The stimulus issues a write to a sole-clean line and, in the lookup cycle right after the request edge, drives a peer read-miss to the same address. The expected result is a shared response with supplied data, followed by exactly one update write. Eviction is reached by filling one index with a sole-dirty line and then missing on another address that maps to the same index. The memory model is then read back through a later miss to confirm the written-back word.

// File: rtl/wupd_pkg.sv
package wupd_pkg;

    typedef enum logic [2:0] {
        CMD_NONE    = 3'd0,
        CMD_RD_MISS = 3'd1,
        CMD_WR_MISS = 3'd2,
        CMD_UPDATE  = 3'd3,
        CMD_WRBACK  = 3'd4
    } bus_cmd_e;

    typedef enum logic [1:0] {
        LS_SOLE_CLEAN   = 2'd0,
        LS_SHARED_CLEAN = 2'd1,
        LS_SOLE_DIRTY   = 2'd2
    } line_st_e;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_TAG,
        FS_EVICT,
        FS_MISS,
        FS_UPD,
        FS_RESP
    } fsm_st_e;

endpackage

// File: rtl/wupd_line_store.sv
module wupd_line_store
    import wupd_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(LINES)-1:0] a_idx,
    output logic                     a_valid,
    output logic [TAG_W-1:0]         a_tag,
    output line_st_e                 a_st,
    output logic [DATA_W-1:0]        a_data,
    input  logic [$clog2(LINES)-1:0] b_idx,
    output logic                     b_valid,
    output logic [TAG_W-1:0]         b_tag,
    output line_st_e                 b_st,
    output logic [DATA_W-1:0]        b_data,
    input  logic                     fw_en,
    input  logic [$clog2(LINES)-1:0] fw_idx,
    input  logic [TAG_W-1:0]         fw_tag,
    input  line_st_e                 fw_st,
    input  logic [DATA_W-1:0]        fw_data,
    input  logic                     sw_en,
    input  logic [$clog2(LINES)-1:0] sw_idx,
    input  line_st_e                 sw_st,
    input  logic [DATA_W-1:0]        sw_data
);
    localparam int IDX_W = $clog2(LINES);

    logic              vld_w  [LINES];
    logic [TAG_W-1:0]  tag_w  [LINES];
    line_st_e          st_w   [LINES];
    logic [DATA_W-1:0] data_w [LINES];

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic              v_q;
        logic [TAG_W-1:0]  t_q;
        line_st_e          s_q;
        logic [DATA_W-1:0] d_q;

        // snoop port wins; the controller never writes while a peer command is active
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                t_q <= '0;
                s_q <= LS_SOLE_CLEAN;
                d_q <= '0;
            end else if (sw_en && sw_idx == IDX_W'(i)) begin
                s_q <= sw_st;
                d_q <= sw_data;
            end else if (fw_en && fw_idx == IDX_W'(i)) begin
                v_q <= 1'b1;
                t_q <= fw_tag;
                s_q <= fw_st;
                d_q <= fw_data;
            end
        end

        assign vld_w[i]  = v_q;
        assign tag_w[i]  = t_q;
        assign st_w[i]   = s_q;
        assign data_w[i] = d_q;
    end

    assign a_valid = vld_w[a_idx];
    assign a_tag   = tag_w[a_idx];
    assign a_st    = st_w[a_idx];
    assign a_data  = data_w[a_idx];
    assign b_valid = vld_w[b_idx];
    assign b_tag   = tag_w[b_idx];
    assign b_st    = st_w[b_idx];
    assign b_data  = data_w[b_idx];
endmodule

// File: rtl/wupd_snoop.sv
module wupd_snoop
    import wupd_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic [2:0]                        snp_cmd,
    input  logic [ADDR_W-1:0]                 snp_addr,
    input  logic [DATA_W-1:0]                 snp_data_in,
    output logic [$clog2(LINES)-1:0]          b_idx,
    input  logic                              b_valid,
    input  logic [ADDR_W-$clog2(LINES)-1:0]   b_tag,
    input  line_st_e                          b_st,
    input  logic [DATA_W-1:0]                 b_data,
    output logic                              snp_shared,
    output logic [DATA_W-1:0]                 snp_data_out,
    output logic                              snp_flush,
    output logic                              sw_en,
    output line_st_e                          sw_st,
    output logic [DATA_W-1:0]                 sw_data
);
    localparam int IDX_W = $clog2(LINES);

    bus_cmd_e cmd;
    logic     match;

    assign cmd   = bus_cmd_e'(snp_cmd);
    assign b_idx = snp_addr[IDX_W-1:0];
    assign match = b_valid && (b_tag == snp_addr[ADDR_W-1:IDX_W]);

    always_comb begin
        snp_shared   = 1'b0;
        snp_data_out = '0;
        snp_flush    = 1'b0;
        sw_en        = 1'b0;
        sw_st        = LS_SHARED_CLEAN;
        sw_data      = b_data;
        unique case (cmd)
            CMD_RD_MISS, CMD_WR_MISS: begin
                if (match) begin
                    snp_shared   = 1'b1;
                    snp_data_out = b_data;
                    snp_flush    = (cmd == CMD_RD_MISS) && (b_st == LS_SOLE_DIRTY);
                    sw_en        = 1'b1;
                end
            end
            CMD_UPDATE: begin
                if (match) begin
                    snp_shared = 1'b1;
                    sw_en      = 1'b1;
                    sw_data    = snp_data_in;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/wupd_fsm.sv
module wupd_fsm
    import wupd_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cpu_req,
    input  logic                              cpu_we,
    input  logic [ADDR_W-1:0]                 cpu_addr,
    input  logic [DATA_W-1:0]                 cpu_wdata,
    output logic                              cpu_ready,
    output logic                              cpu_done,
    output logic [DATA_W-1:0]                 cpu_rdata,
    input  logic                              peer_busy,
    input  logic                              bus_shared,
    input  logic [DATA_W-1:0]                 bus_rdata,
    output bus_cmd_e                          bus_cmd,
    output logic [ADDR_W-1:0]                 bus_addr,
    output logic [DATA_W-1:0]                 bus_wdata,
    output logic [$clog2(LINES)-1:0]          a_idx,
    input  logic                              a_valid,
    input  logic [ADDR_W-$clog2(LINES)-1:0]   a_tag,
    input  line_st_e                          a_st,
    input  logic [DATA_W-1:0]                 a_data,
    output logic                              fw_en,
    output logic [ADDR_W-$clog2(LINES)-1:0]   fw_tag,
    output line_st_e                          fw_st,
    output logic [DATA_W-1:0]                 fw_data
);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    fsm_st_e           st_q, st_d;
    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [TAG_W-1:0]  req_tag;
    logic              hit;

    assign a_idx   = addr_q[IDX_W-1:0];
    assign req_tag = addr_q[ADDR_W-1:IDX_W];
    assign hit     = a_valid && (a_tag == req_tag);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= FS_IDLE;
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == FS_IDLE && cpu_req) begin
                we_q    <= cpu_we;
                addr_q  <= cpu_addr;
                wdata_q <= cpu_wdata;
            end
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FS_IDLE:  if (cpu_req) st_d = FS_TAG;
            FS_TAG: begin
                if (!peer_busy) begin
                    if (hit)
                        st_d = (we_q && a_st == LS_SHARED_CLEAN) ? FS_UPD : FS_RESP;
                    else if (a_valid && a_st == LS_SOLE_DIRTY)
                        st_d = FS_EVICT;
                    else
                        st_d = FS_MISS;
                end
            end
            FS_EVICT: if (!peer_busy) st_d = FS_MISS;
            FS_MISS:  if (!peer_busy) st_d = (we_q && bus_shared) ? FS_UPD : FS_RESP;
            FS_UPD:   if (!peer_busy) st_d = FS_RESP;
            FS_RESP:  st_d = FS_IDLE;
            default:  st_d = FS_IDLE;
        endcase
    end

    always_comb begin
        cpu_ready = (st_q == FS_IDLE);
        cpu_done  = (st_q == FS_RESP);
        cpu_rdata = a_data;
        bus_cmd   = CMD_NONE;
        bus_addr  = addr_q;
        bus_wdata = '0;
        fw_en     = 1'b0;
        fw_tag    = req_tag;
        fw_st     = LS_SOLE_DIRTY;
        fw_data   = wdata_q;
        if (!peer_busy) begin
            unique case (st_q)
                FS_TAG: begin
                    fw_en = hit && we_q && (a_st != LS_SHARED_CLEAN);
                end
                FS_EVICT: begin
                    bus_cmd   = CMD_WRBACK;
                    bus_addr  = {a_tag, a_idx};
                    bus_wdata = a_data;
                end
                FS_MISS: begin
                    bus_cmd = we_q ? CMD_WR_MISS : CMD_RD_MISS;
                    fw_en   = 1'b1;
                    if (we_q) begin
                        fw_st = bus_shared ? LS_SHARED_CLEAN : LS_SOLE_DIRTY;
                    end else begin
                        fw_st   = bus_shared ? LS_SHARED_CLEAN : LS_SOLE_CLEAN;
                        fw_data = bus_rdata;
                    end
                end
                FS_UPD: begin
                    bus_cmd   = CMD_UPDATE;
                    bus_wdata = wdata_q;
                    fw_en     = 1'b1;
                    fw_st     = LS_SHARED_CLEAN;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/wupd_coherence_ctrl.sv
module wupd_coherence_ctrl
    import wupd_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic [2:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_shared,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic [2:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [DATA_W-1:0] snp_data_in,
    output logic              snp_shared,
    output logic [DATA_W-1:0] snp_data_out,
    output logic              snp_flush
);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  a_idx, b_idx;
    logic              a_valid, b_valid;
    logic [TAG_W-1:0]  a_tag, b_tag, fw_tag;
    line_st_e          a_st, b_st, fw_st, sw_st;
    logic [DATA_W-1:0] a_data, b_data, fw_data, sw_data;
    logic              fw_en, sw_en;
    bus_cmd_e          cmd_int;
    logic              peer_busy;

    assign peer_busy = (snp_cmd != 3'd0);
    assign bus_cmd   = cmd_int;

    wupd_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .a_idx(a_idx), .a_valid(a_valid), .a_tag(a_tag), .a_st(a_st), .a_data(a_data),
        .b_idx(b_idx), .b_valid(b_valid), .b_tag(b_tag), .b_st(b_st), .b_data(b_data),
        .fw_en(fw_en), .fw_idx(a_idx), .fw_tag(fw_tag), .fw_st(fw_st), .fw_data(fw_data),
        .sw_en(sw_en), .sw_idx(b_idx), .sw_st(sw_st), .sw_data(sw_data)
    );

    wupd_snoop #(.LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_snoop (
        .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_data_in(snp_data_in),
        .b_idx(b_idx), .b_valid(b_valid), .b_tag(b_tag), .b_st(b_st), .b_data(b_data),
        .snp_shared(snp_shared), .snp_data_out(snp_data_out), .snp_flush(snp_flush),
        .sw_en(sw_en), .sw_st(sw_st), .sw_data(sw_data)
    );

    wupd_fsm #(.LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .peer_busy(peer_busy), .bus_shared(bus_shared), .bus_rdata(bus_rdata),
        .bus_cmd(cmd_int), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .a_idx(a_idx), .a_valid(a_valid), .a_tag(a_tag), .a_st(a_st), .a_data(a_data),
        .fw_en(fw_en), .fw_tag(fw_tag), .fw_st(fw_st), .fw_data(fw_data)
    );
endmodule

// File: rtl/wupd_coherence_checker.sv
module wupd_coherence_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_ready,
    input logic       cpu_done,
    input logic [2:0] bus_cmd,
    input logic       bus_shared,
    input logic [2:0] snp_cmd,
    input logic       snp_shared,
    input logic       snp_flush
);
    AST_QUIET_UNDER_PEER: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_cmd != 3'd0) |-> (bus_cmd == 3'd0)); // R11

    AST_SHARED_WRMISS_UPDATES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd == 3'd2 && bus_shared) |=> (bus_cmd == 3'd3 || snp_cmd != 3'd0)); // R4

    AST_WRBACK_THEN_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd == 3'd4) |=> (bus_cmd == 3'd1 || bus_cmd == 3'd2 || snp_cmd != 3'd0)); // R7

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> (!cpu_done && cpu_ready)); // R2

    AST_FLUSH_WITH_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        snp_flush |-> (snp_shared && snp_cmd == 3'd1)); // R8

    AST_NO_CMD_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> (bus_cmd == 3'd0)); // R1
endmodule

bind wupd_coherence_ctrl wupd_coherence_checker u_checker (
    .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready), .cpu_done(cpu_done),
    .bus_cmd(bus_cmd), .bus_shared(bus_shared), .snp_cmd(snp_cmd),
    .snp_shared(snp_shared), .snp_flush(snp_flush)
);

// File: tb/wupd_coherence_ctrl_bench.sv
module wupd_coherence_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = CLK_PERIOD / 4;
    localparam int LINES      = 4;
    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 16;
    localparam int SC = 0, MC = 1, SI = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_req = 1'b0, cpu_we = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [DATA_W-1:0] cpu_wdata = '0;
    logic              cpu_ready, cpu_done;
    logic [DATA_W-1:0] cpu_rdata;
    logic [2:0]        bus_cmd;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wdata;
    logic              bus_shared;
    logic [DATA_W-1:0] bus_rdata;
    logic [2:0]        snp_cmd = '0;
    logic [ADDR_W-1:0] snp_addr = '0;
    logic [DATA_W-1:0] snp_data_in = '0;
    logic              snp_shared, snp_flush;
    logic [DATA_W-1:0] snp_data_out;

    logic              peer_shared = 1'b0;
    logic [DATA_W-1:0] peer_data = '0;
    logic [DATA_W-1:0] mem [256];

    bit  mv    [LINES];
    int  mtag  [LINES];
    int  mst   [LINES];
    int  mdata [LINES];

    typedef struct { int cmd; int addr; int data; bit chk; } ev_t;
    ev_t   expq[$];
    int    checks = 0, fails = 0;
    string cur_r = "R1";
    bit    run = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign bus_shared = peer_shared && (bus_cmd == 3'd1 || bus_cmd == 3'd2 || bus_cmd == 3'd3);
    assign bus_rdata  = peer_shared ? peer_data : mem[bus_addr];

    wupd_coherence_ctrl #(.LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wupd_coherence_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_shared(bus_shared), .bus_rdata(bus_rdata),
        .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_data_in(snp_data_in),
        .snp_shared(snp_shared), .snp_data_out(snp_data_out), .snp_flush(snp_flush)
    );

    task automatic check(string r, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
        end
    endtask

    task automatic push(int cmd, int addr, int data, bit chk);
        ev_t e;
        e.cmd = cmd; e.addr = addr; e.data = data; e.chk = chk;
        expq.push_back(e);
    endtask

    // reference bus monitor, compared every clock
    initial forever begin
        @(negedge clk);
        #(Q);
        if (run && rst_n && bus_cmd != 3'd0) begin
            if (expq.size() == 0) begin
                check(cur_r, "unexpected bus command", int'(bus_cmd), 0);
            end else begin
                ev_t e;
                e = expq.pop_front();
                check(cur_r, "bus command", int'(bus_cmd), e.cmd);
                check(cur_r, "bus address", int'(bus_addr), e.addr);
                if (e.chk) check(cur_r, "bus data", int'(bus_wdata), e.data);
            end
            if (bus_cmd == 3'd3 || bus_cmd == 3'd4) mem[bus_addr] = bus_wdata;
        end
    end

    task automatic model_snoop(int cmd, int addr, int d, output bit esh, output int esup, output bit efl);
        int idx = addr % LINES;
        int tg  = addr / LINES;
        esh = 0; esup = 0; efl = 0;
        if (mv[idx] && mtag[idx] == tg && cmd >= 1 && cmd <= 3) begin
            esh = 1;
            if (cmd != 3) esup = mdata[idx];
            if (cmd == 1 && mst[idx] == SI) begin
                efl = 1;
                mem[addr] = DATA_W'(mdata[idx]);
            end
            if (cmd == 3) mdata[idx] = d;
            mst[idx] = MC;
        end
    endtask

    task automatic drive_snoop_check(string r, int cmd, int addr, int d);
        bit esh, efl;
        int esup;
        model_snoop(cmd, addr, d, esh, esup, efl);
        snp_cmd = 3'(cmd); snp_addr = ADDR_W'(addr); snp_data_in = DATA_W'(d);
        #(Q);
        check(r, "snp_shared", int'(snp_shared), int'(esh));
        check(r, "snp_flush", int'(snp_flush), int'(efl));
        if (esh && cmd != 3) check(r, "snp_data_out", int'(snp_data_out), esup);
        @(negedge clk);
        snp_cmd = '0;
    endtask

    task automatic snoop(string r, int cmd, int addr, int d);
        @(negedge clk);
        drive_snoop_check(r, cmd, addr, d);
    endtask

    task automatic do_req(string r, bit we, int addr, int wd, bit shared, int pd, bit race);
        int idx = addr % LINES;
        int tg  = addr / LINES;
        int erd;
        int n = 0;
        bit dummy_sh, dummy_fl;
        int dummy_sup;
        if (race) model_snoop(1, addr, 0, dummy_sh, dummy_sup, dummy_fl);
        if (mv[idx] && mtag[idx] == tg) begin
            if (we) begin
                if (mst[idx] == MC) push(3, addr, wd, 1);
                else mst[idx] = SI;
                mdata[idx] = wd;
            end
        end else begin
            if (mv[idx] && mst[idx] == SI) push(4, mtag[idx] * LINES + idx, mdata[idx], 1);
            push(we ? 2 : 1, addr, 0, 0);
            mv[idx] = 1; mtag[idx] = tg;
            if (we) begin
                mdata[idx] = wd;
                if (shared) begin mst[idx] = MC; push(3, addr, wd, 1); end
                else mst[idx] = SI;
            end else begin
                mdata[idx] = shared ? pd : int'(mem[addr]);
                mst[idx]   = shared ? MC : SC;
            end
        end
        erd = mdata[idx];
        cur_r = r; peer_shared = shared; peer_data = DATA_W'(pd);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = ADDR_W'(addr); cpu_wdata = DATA_W'(wd);
        @(negedge clk);
        cpu_req = 1'b0;
        if (race) begin
            // peer read-miss in the lookup cycle (R11)
            snp_cmd = 3'd1; snp_addr = ADDR_W'(addr);
            #(Q);
            check("R11", "race snp_shared", int'(snp_shared), 1);
            check("R11", "race snp_data_out", int'(snp_data_out), dummy_sup);
            @(negedge clk);
            snp_cmd = '0;
        end
        forever begin
            #(Q);
            if (cpu_done) break;
            @(negedge clk);
            n++;
            if (n > 50) break;
        end
        check(r, "cpu_done seen", int'(cpu_done), 1);
        check(r, "cpu_rdata", int'(cpu_rdata), erd);
        check(r, "pending bus commands", expq.size(), 0);
        expq.delete();
        @(negedge clk);
        peer_shared = 1'b0;
        check(r, "ready after done", int'(cpu_ready), 1);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        checks++; fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = DATA_W'((i * 37 + 5) & 16'hffff);
        for (int i = 0; i < LINES; i++) begin mv[i] = 0; mtag[i] = 0; mst[i] = SC; mdata[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        run = 1'b1;
        #(Q);
        // R1 reset state
        check("R1", "cpu_ready", int'(cpu_ready), 1);
        check("R1", "cpu_done", int'(cpu_done), 0);
        check("R1", "bus_cmd", int'(bus_cmd), 0);
        snoop("R1", 1, 8'h10, 0);
        // R3 read miss unshared -> sole-clean
        do_req("R3", 0, 8'h10, 0, 0, 0, 0);
        // R5 write hit on sole-clean: local, becomes sole-dirty
        do_req("R5", 1, 8'h10, 16'h0A0A, 0, 0, 0);
        // R8 peer read-miss on sole-dirty: flush, supply, becomes shared
        snoop("R8", 1, 8'h10, 0);
        // R6 write hit on shared: one update
        do_req("R6", 1, 8'h10, 16'h0B0B, 0, 0, 0);
        // R2 read hit
        do_req("R2", 0, 8'h10, 0, 0, 0, 0);
        // R9 peer update overwrites
        snoop("R9", 3, 8'h10, 16'hBEEF);
        do_req("R9", 0, 8'h10, 0, 0, 0, 0);
        // R10 non-matching and write-back snoops ignored
        snoop("R10", 1, 8'h14, 0);
        snoop("R10", 4, 8'h10, 16'h1111);
        snoop("R10", 3, 8'h24, 16'h2222);
        do_req("R10", 0, 8'h10, 0, 0, 0, 0);
        // R3 read miss with sharers -> shared-clean, proven by update on write hit
        do_req("R3", 0, 8'h21, 0, 1, 16'h1234, 0);
        do_req("R3", 1, 8'h21, 16'h5678, 0, 0, 0);
        // R4 write miss unshared -> sole-dirty, shown by flush
        do_req("R4", 1, 8'h22, 16'h3333, 0, 0, 0);
        snoop("R4", 1, 8'h22, 0);
        // R4 write miss shared -> write-miss then update, shared-clean
        do_req("R4", 1, 8'h23, 16'h4444, 1, 16'h9999, 0);
        do_req("R4", 1, 8'h23, 16'h4545, 0, 0, 0);
        // R8 peer write-miss on shared line: supply, no flush
        snoop("R8", 2, 8'h23, 0);
        // R7 clean victim silent, dirty victim written back
        do_req("R7", 1, 8'h07, 16'h7777, 0, 0, 0);
        do_req("R7", 0, 8'h0B, 0, 0, 0, 0);
        do_req("R7", 0, 8'h07, 0, 0, 0, 0);
        check("R7", "memory holds written-back word", int'(mem[8'h07]), 16'h7777);
        // R11 peer read-miss during lookup of a write to a sole-clean line
        do_req("R11", 1, 8'h07, 16'hC0DE, 0, 0, 1);
        snoop("R11", 1, 8'h07, 0);
        finish_run();
    end
endmodule